// File: doc/BRIEF.md
# Interlocked Glitch-Free Base Clock Selector

This block derives a base clock from one of two unrelated source clocks, a crystal reference and a PLL VCO output, and divides the chosen source by two. Software controls it through an 8-bit control register on a bus clock. The register holds a PLL enable bit, which leaves the block on `pll_en` to switch on an external PLL, and a source select bit. The write logic interlocks the two bits: the VCO can only be selected while the PLL is enabled, and the PLL cannot be turned off while the VCO is selected.

A source change never produces a short pulse on the output. Each source has a gate leg with two states, `LEG_OFF` and `LEG_ON`. Each leg runs on the falling edge of its own clock and has its own synchronizer. A leg moves `LEG_OFF -> LEG_ON` only after its synchronizer shows that its source is wanted and the other leg is off. It moves `LEG_ON -> LEG_OFF` when the synchronized request drops.

In the bus domain, a handover controller has two states, `HO_SETTLED` and `HO_MOVING`. It passes a new selection to the legs (`HO_SETTLED -> HO_MOVING`) only when the previous handover has been confirmed. It returns `HO_MOVING -> HO_SETTLED` once the synchronized leg states show the target leg on and the other leg off. Reset enters `HO_MOVING` with the crystal as target. While no gate is open, the divider holds its level, so the output is frozen during the handover.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the control register reads 8'h8F: PLL enable is 1, select is 0, and `pll_en` is 1.
- R2: Bit 7 is PLL enable and drives `pll_en`. Bit 6 is select (0 = crystal, 1 = VCO). Bits 5:4 always read 0 and bits 3:0 always read 1, whatever is written.
- R3: A write sets the select bit only if PLL enable is 1 both before and after that write. A disabled PLL therefore needs one write to enable it and a second write to select the VCO.
- R4: While the select bit is 1, a write cannot clear PLL enable; that bit stays 1.
- R5: In every bus cycle in which `stop_req` is 1, the select bit is cleared. PLL enable is unaffected except by a write in the same cycle.
- R6: `base_clk` has exactly twice the period of the selected source: 60 ns for the 30 ns crystal and 34 ns for the 17 ns VCO in the bench.
- R7: After a write changes the select bit, `base_clk` runs at the new rate within about four cycles of each source plus a few bus cycles. The output holds its level while the handover is in progress.
- R8: The two source gates are never open at the same time, and no high or low phase of `base_clk` is shorter than half the period of the faster source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop-mode request; clears the select bit |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| xtal_clk | input | 1 | Crystal reference clock |
| vco_clk | input | 1 | PLL VCO clock |
| pll_en | output | 1 | PLL enable, register bit 7 |
| base_clk | output | 1 | Selected source divided by two |

## Verification
The bench targets the combined writes where both bits change in one write. A wrong interlock would let a single write clear the PLL and select the VCO, leaving the VCO selected with the PLL off. It also targets writes that coincide with a stop request; a design that gave the write priority would leave the VCO selected in stop mode. Random writes at bus speed toggle the select bit faster than a handover can finish. A selector that forwarded every change would open both gates or cut a phase short, and the minimum-phase monitor or the divided period would show it. Directed switches in both directions measure the output period after a bounded wait, which catches a handover that stalls or a divider that runs on the wrong source.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;

    localparam int unsigned CTRL_W   = 8;
    localparam int unsigned PLL_BIT  = 7;
    localparam int unsigned SEL_BIT  = 6;
    localparam int unsigned ONES_W   = 4;
    localparam int unsigned NSRC     = 2;
    localparam int unsigned SRC_XTAL = 0;
    localparam int unsigned SRC_VCO  = 1;

    typedef enum logic {
        LEG_OFF = 1'b0,
        LEG_ON  = 1'b1
    } leg_state_t;

    typedef enum logic {
        HO_SETTLED = 1'b0,
        HO_MOVING  = 1'b1
    } ho_state_t;

endpackage

// File: rtl/clk_sw_sync.sv
module clk_sw_sync #(
    parameter int unsigned STAGES  = 2,
    parameter int unsigned WIDTH   = 1,
    parameter bit          FALLING = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        if (FALLING) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/clk_sel_regs.sv
module clk_sel_regs
    import clk_sw_pkg::*;
(
    input  logic              bus_clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              pll_on,
    output logic              sel_vco,
    output logic [CTRL_W-1:0] rd_data
);

    logic nx_pll;
    logic nx_sel;

    // Interlock: PLL held on while VCO selected; select needs PLL on before and after.
    always_comb begin
        nx_pll = sel_vco ? 1'b1 : wr_data[PLL_BIT];
        nx_sel = wr_data[SEL_BIT] & pll_on & nx_pll;
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_on  <= 1'b1;
            sel_vco <= 1'b0;
        end else begin
            if (wr_en) pll_on <= nx_pll;
            if (stop_req)   sel_vco <= 1'b0;
            else if (wr_en) sel_vco <= nx_sel;
        end
    end

    always_comb begin
        rd_data               = '0;
        rd_data[ONES_W-1:0]   = '1;
        rd_data[PLL_BIT]      = pll_on;
        rd_data[SEL_BIT]      = sel_vco;
    end

endmodule

// File: rtl/clk_sel_handover.sv
module clk_sel_handover
    import clk_sw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            bus_clk,
    input  logic            rst_n,
    input  logic            sel_req,
    input  logic [NSRC-1:0] leg_on,
    output logic            sel_eff
);

    logic [NSRC-1:0] on_s;
    ho_state_t       st_q, st_d;
    logic            eff_d;
    logic            target_ok;

    clk_sw_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (NSRC),
        .FALLING(1'b0)
    ) u_on_sync (
        .clk  (bus_clk),
        .rst_n(rst_n),
        .d    (leg_on),
        .q    (on_s)
    );

    always_comb begin
        target_ok = sel_eff ? (on_s[SRC_VCO] & ~on_s[SRC_XTAL])
                            : (on_s[SRC_XTAL] & ~on_s[SRC_VCO]);
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= HO_MOVING;
            sel_eff <= 1'b0;
        end else begin
            st_q    <= st_d;
            sel_eff <= eff_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        eff_d = sel_eff;
        unique case (st_q)
            HO_SETTLED: begin
                if (sel_req != sel_eff) begin
                    eff_d = sel_req;
                    st_d  = HO_MOVING;
                end
            end
            HO_MOVING: begin
                if (target_ok) st_d = HO_SETTLED;
            end
            default: st_d = HO_MOVING;
        endcase
    end

endmodule

// File: rtl/clk_gate_leg.sv
module clk_gate_leg
    import clk_sw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic want,
    input  logic peer_on,
    output logic leg_on,
    output logic gated_clk
);

    logic       arm_async;
    logic       arm_sync;
    leg_state_t state_q, state_d;

    assign arm_async = want & ~peer_on;

    clk_sw_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (1),
        .FALLING(1'b1)
    ) u_arm_sync (
        .clk  (src_clk),
        .rst_n(rst_n),
        .d    (arm_async),
        .q    (arm_sync)
    );

    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) state_q <= LEG_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEG_OFF: if (arm_sync)  state_d = LEG_ON;
            LEG_ON:  if (!arm_sync) state_d = LEG_OFF;
            default: state_d = LEG_OFF;
        endcase
    end

    // Enable changes only while the source is low, so the gate cannot chop a pulse.
    always_comb begin
        leg_on    = (state_q == LEG_ON);
        gated_clk = src_clk & leg_on;
    end

endmodule

// File: rtl/clk_half_div.sv
module clk_half_div (
    input  logic src_clk,
    input  logic rst_n,
    output logic half_clk
);

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) half_clk <= 1'b0;
        else        half_clk <= ~half_clk;
    end

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
    import clk_sw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              xtal_clk,
    input  logic              vco_clk,
    output logic              pll_en,
    output logic              base_clk
);

    logic            pll_q;
    logic            sel_q;
    logic            sel_eff;
    logic [NSRC-1:0] src_clks;
    logic [NSRC-1:0] want;
    logic [NSRC-1:0] leg_on;
    logic [NSRC-1:0] gated;
    logic            mux_clk;

    clk_sel_regs u_regs (
        .bus_clk (bus_clk),
        .rst_n   (rst_n),
        .stop_req(stop_req),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pll_on  (pll_q),
        .sel_vco (sel_q),
        .rd_data (rd_data)
    );

    clk_sel_handover #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_handover (
        .bus_clk(bus_clk),
        .rst_n  (rst_n),
        .sel_req(sel_q),
        .leg_on (leg_on),
        .sel_eff(sel_eff)
    );

    assign src_clks[SRC_XTAL] = xtal_clk;
    assign src_clks[SRC_VCO]  = vco_clk;
    assign want[SRC_XTAL]     = ~sel_eff;
    assign want[SRC_VCO]      = sel_eff;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_leg
            clk_gate_leg #(
                .SYNC_STAGES(SYNC_STAGES)
            ) u_leg (
                .src_clk  (src_clks[g]),
                .rst_n    (rst_n),
                .want     (want[g]),
                .peer_on  (leg_on[NSRC-1-g]),
                .leg_on   (leg_on[g]),
                .gated_clk(gated[g])
            );
        end
    endgenerate

    assign mux_clk = |gated;

    clk_half_div u_div (
        .src_clk (mux_clk),
        .rst_n   (rst_n),
        .half_clk(base_clk)
    );

    assign pll_en = pll_q;

endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk
    import clk_sw_pkg::*;
(
    input logic              bus_clk,
    input logic              rst_n,
    input logic              stop_req,
    input logic              wr_en,
    input logic [CTRL_W-1:0] rd_data,
    input logic              pll_en,
    input logic              sel_bit,
    input logic [NSRC-1:0]   leg_on
);

    p_reset_r1: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pll_en && !sel_bit));

    p_pll_port_r2: assert property (@(posedge bus_clk) disable iff (!rst_n)
        rd_data[PLL_BIT] == pll_en);

    p_sel_needs_pll_r3: assert property (@(posedge bus_clk) disable iff (!rst_n)
        sel_bit |-> pll_en);

    p_pll_held_r4: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (wr_en && sel_bit) |=> pll_en);

    p_stop_clears_r5: assert property (@(posedge bus_clk) disable iff (!rst_n)
        stop_req |=> !sel_bit);

    p_one_gate_r8: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $countones(leg_on) <= 1);

endmodule

bind clk_src_switch clk_src_switch_chk u_chk (
    .bus_clk (bus_clk),
    .rst_n   (rst_n),
    .stop_req(stop_req),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .pll_en  (pll_en),
    .sel_bit (sel_q),
    .leg_on  (leg_on)
);

// File: tb/tb_clk_src_switch.sv
`timescale 1ns/1ps
module tb_clk_src_switch;

    localparam real BUS_H  = 2.0;
    localparam real XTAL_H = 15.0;
    localparam real VCO_H  = 8.5;
    localparam real SETTLE = 220.0;

    logic       bus_clk  = 1'b0;
    logic       xtal_clk = 1'b0;
    logic       vco_clk  = 1'b0;
    logic       rst_n    = 1'b0;
    logic       stop_req = 1'b0;
    logic       wr_en    = 1'b0;
    logic [7:0] wr_data  = 8'h00;
    logic [7:0] rd_data;
    logic       pll_en;
    logic       base_clk;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic [7:0] model = 8'h8F;

    real last_edge = 0.0;
    real min_phase = 1.0e9;
    bit  mon       = 1'b0;

    always #(BUS_H)  bus_clk  = ~bus_clk;
    always #(XTAL_H) xtal_clk = ~xtal_clk;
    always #(VCO_H)  vco_clk  = ~vco_clk;

    clk_src_switch dut (
        .bus_clk (bus_clk),
        .rst_n   (rst_n),
        .stop_req(stop_req),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .xtal_clk(xtal_clk),
        .vco_clk (vco_clk),
        .pll_en  (pll_en),
        .base_clk(base_clk)
    );

    always @(base_clk) begin
        if (mon && ($realtime - last_edge < min_phase)) min_phase = $realtime - last_edge;
        last_edge = $realtime;
    end

    function automatic logic [7:0] next_ctrl(logic [7:0] cur, logic [7:0] d, bit wr, bit stp);
        logic p, s, np, ns;
        p  = cur[7];
        s  = cur[6];
        np = p;
        ns = s;
        if (wr) begin
            np = s ? 1'b1 : d[7];
            ns = d[6] & p & np;
        end
        if (stp) ns = 1'b0;
        return {np, ns, 2'b00, 4'hF};
    endfunction

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_reg(string req);
        check8(req, rd_data, model);
        check8({req, " pll_en"}, {7'd0, pll_en}, {7'd0, model[7]});
    endtask

    task automatic bus_op(logic [7:0] d, bit wr, bit stp);
        @(negedge bus_clk);
        wr_en    = wr;
        wr_data  = d;
        stop_req = stp;
        @(negedge bus_clk);
        wr_en    = 1'b0;
        stop_req = 1'b0;
        model    = next_ctrl(model, d, wr, stp);
    endtask

    task automatic measure(string req, real exp);
        real t0, per;
        @(posedge base_clk);
        t0 = $realtime;
        @(posedge base_clk);
        per = $realtime - t0;
        checks++;
        if (per < exp - 0.5 || per > exp + 0.5) begin
            fails++;
            $display("FAIL %s period actual=%0.3f expected=%0.3f", req, per, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (10) @(negedge bus_clk);
        rst_n = 1'b1;
        @(negedge bus_clk);
        // R1: reset state
        check8("R1 reset readback", rd_data, 8'h8F);
        check8("R1 pll_en", {7'd0, pll_en}, 8'h01);
        #(SETTLE);
        @(posedge base_clk);
        mon = 1'b1;
        measure("R6 crystal rate after reset", 60.0);

        // R3: select refused while PLL off; two-step enable
        bus_op(8'h40, 1'b1, 1'b0);
        chk_reg("R3 set sel with pll cleared in same write");
        check8("R3 expect 0F", rd_data, 8'h0F);
        bus_op(8'h40, 1'b1, 1'b0);
        chk_reg("R3 set sel while pll off");
        bus_op(8'hC0, 1'b1, 1'b0);
        chk_reg("R3 first write enables pll only");
        check8("R3 expect 8F", rd_data, 8'h8F);
        bus_op(8'hC0, 1'b1, 1'b0);
        chk_reg("R3 second write selects vco");
        check8("R3 expect CF", rd_data, 8'hCF);
        #(SETTLE);
        measure("R7 R6 vco rate after handover", 34.0);

        // R4: PLL cannot be cleared while VCO selected
        bus_op(8'h40, 1'b1, 1'b0);
        chk_reg("R4 clear pll while sel");
        check8("R4 expect CF", rd_data, 8'hCF);
        bus_op(8'h00, 1'b1, 1'b0);
        chk_reg("R4 clear both while sel");
        check8("R4 expect 8F", rd_data, 8'h8F);
        #(SETTLE);
        measure("R7 R6 crystal rate after handover", 60.0);

        // R2: fixed bits
        bus_op(8'hFF, 1'b1, 1'b0);
        chk_reg("R2 all ones write");
        check8("R2 expect CF", rd_data, 8'hCF);
        bus_op(8'h30, 1'b1, 1'b0);
        chk_reg("R2 bits 5:4 write");
        bus_op(8'hC0, 1'b1, 1'b0);
        chk_reg("R2 restore");

        // R5: stop request
        bus_op(8'h00, 1'b0, 1'b1);
        chk_reg("R5 stop clears sel");
        check8("R5 expect 8F", rd_data, 8'h8F);
        bus_op(8'hC0, 1'b1, 1'b1);
        chk_reg("R5 stop beats select write");
        check8("R5 expect 8F with write", rd_data, 8'h8F);

        // Random writes, stops and idle gaps
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            bus_op(r[7:0], r[12] | r[13], r[11:8] == 4'd0);
            chk_reg("R2 R3 R4 R5 random");
            repeat (r[18:14]) @(negedge bus_clk);
        end

        bus_op(8'hC0, 1'b1, 1'b0);
        bus_op(8'hC0, 1'b1, 1'b0);
        chk_reg("R3 final select vco");
        #(SETTLE);
        measure("R6 vco rate after random", 34.0);
        bus_op(8'h80, 1'b1, 1'b0);
        chk_reg("R4 final back to crystal");
        #(SETTLE);
        measure("R6 crystal rate after random", 60.0);

        // R8: no runt phase anywhere in the run
        checks++;
        if (min_phase < VCO_H) begin
            fails++;
            $display("FAIL R8 min phase actual=%0.3f expected>=%0.3f", min_phase, VCO_H);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule